// File: doc/BRIEF.md
# Serial Peripheral Target with Held Transmit Byte

This block is the target side of a four-wire serial peripheral link. It moves one byte per transfer: the byte that the host logic left in a holding register goes out on MISO, most significant bit first, while the byte arriving on MOSI is assembled and then presented on a parallel output. All four combinations of clock polarity and clock phase are supported. The phase setting also sets which event opens a transfer. With phase 0, the select line going low opens the transfer. With phase 1, the first clock edge seen while selected opens it.

The serial pins are brought into the system clock domain through two-stage synchronizers, and edges are detected on the synchronized copies. The serial clock must therefore run well below the system clock. The host logic writes the holding register at any time. A write that lands while a byte is in flight does not disturb that byte. The written value is used when the next transfer opens. A transfer that loses its select before the eighth bit is thrown away.

Top module: `spi_tgt_buffered`

## Requirements
- R1: After reset, miso_oe_o is 0, done_o is 0 and rx_data_o is all zeros.
- R2: miso_oe_o is 1 while the synchronized select (ss_n_i low) is active and 0 while it is high, lagging the pin by the synchronizer and one register.
- R3: With cfg_cpha = 0, a falling select opens the transfer and MISO carries bit 7 of the held byte before the first clock edge. A master sampling on each leading edge recovers the held byte MSB first.
- R4: With cfg_cpha = 1, the first serial clock edge while selected opens the transfer and puts bit 7 on MISO. A master sampling on each trailing edge recovers the held byte MSB first.
- R5: MOSI is captured on the leading edge for cfg_cpha = 0 and on the trailing edge for cfg_cpha = 1, first bit into bit 7. After the eighth capture, rx_data_o holds the byte.
- R6: cfg_cpol = 0 means the clock idles low and the leading edge is rising. cfg_cpol = 1 means it idles high and the leading edge is falling. Both polarities give the same data results.
- R7: done_o is high for exactly one system clock per completed byte, and never for two cycles in a row.
- R8: A write on wr_en_i/wr_data_i during a transfer leaves the byte being shifted unchanged. The written value is sent by the next transfer.
- R9: With cfg_cpha = 1 and select held low, consecutive bytes run back to back. Each byte opens on the next leading edge and sends the held value current at that moment.
- R10: Select rising before the eighth capture aborts the byte. No done_o pulse occurs, rx_data_o is unchanged, and the next transfer starts again from bit 7 of the held byte.
- R11: Without a new write, the next transfer sends the same held byte again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Serial clock phase; picks start event and capture edge |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_n_i | input | 1 | Active-low select |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Drive enable for the MISO pad |
| wr_en_i | input | 1 | Host write strobe for the held byte |
| wr_data_i | input | 8 | Host write data |
| rx_data_o | output | 8 | Last fully received byte |
| done_o | output | 1 | One-cycle pulse per completed byte |

## Verification
Every polarity and phase combination is swept with all-zeros, all-ones and a set of computed mixed bytes. The byte sent and the byte received differ in every transfer, so a swapped direction or a shifted bit shows up in one of the two. Writes placed in the middle of a byte show whether the locked shift register and the held register stay separate. A select held low over two bytes in phase 1 tells the back-to-back start apart from a select-driven start. A select pulled mid-byte shows that an aborted byte leaves no pulse and no partial data, and that the next byte restarts from bit 7.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_SHIFT = 1'b1
    } phase_t;

    typedef struct packed {
        logic lead;
        logic trail;
    } sck_ev_t;

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int unsigned WIDTH = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q[g] <= RST_VAL;
                end else begin
                    stg_q[g] <= stg_d[g];
                end
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/spi_tgt_edge.sv
module spi_tgt_edge
    import spi_tgt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cpol_i,
    input  logic    sck_i,
    input  logic    ss_n_i,
    output sck_ev_t ev_o,
    output logic    ss_fall_o
);

    typedef struct packed {
        logic sck_prev;
        logic ss_prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     rise, fall;

    always_comb begin
        st_d.sck_prev = sck_i;
        st_d.ss_prev  = ss_n_i;
        rise          = sck_i & ~st_q.sck_prev;
        fall          = ~sck_i & st_q.sck_prev;
        ev_o.lead     = cpol_i ? fall : rise;
        ev_o.trail    = cpol_i ? rise : fall;
        ss_fall_o     = st_q.ss_prev & ~ss_n_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sck_prev <= 1'b0;
            st_q.ss_prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    AST_EDGES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_o.lead && ev_o.trail)); // R6

endmodule

// File: rtl/spi_tgt_shifter.sv
module spi_tgt_shifter
    import spi_tgt_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cpha_i,
    input  sck_ev_t      ev_i,
    input  logic         ss_fall_i,
    input  logic         ss_n_i,
    input  logic         mosi_i,
    input  logic [W-1:0] load_i,
    output logic         miso_o,
    output logic         miso_oe_o,
    output logic [W-1:0] rx_data_o,
    output logic         done_o
);

    localparam int unsigned CW   = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        phase_t        ph;
        logic [CW-1:0] cnt;
        logic [W-1:0]  tsh;
        logic [W-1:0]  rsh;
        logic          miso;
        logic          oe;
        logic [W-1:0]  rx;
        logic          done;
    } shf_st_t;

    shf_st_t      st_d, st_q;
    logic         sample_ev, shift_ev, start_ev;
    logic [W-1:0] rx_next;

    always_comb begin
        sample_ev = cpha_i ? ev_i.trail : ev_i.lead;
        shift_ev  = cpha_i ? ev_i.lead  : ev_i.trail;
        start_ev  = cpha_i ? ev_i.lead  : ss_fall_i;
        rx_next   = {st_q.rsh[W-2:0], mosi_i};

        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.oe   = ~ss_n_i;

        if (ss_n_i) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
        end else if (st_q.ph == PH_IDLE) begin
            if (start_ev) begin
                st_d.ph   = PH_SHIFT;
                st_d.cnt  = '0;
                st_d.tsh  = load_i;
                st_d.miso = load_i[W-1];
                st_d.rsh  = '0;
            end
        end else begin
            if (sample_ev) begin
                st_d.rsh = rx_next;
                if (st_q.cnt == LAST) begin
                    st_d.ph   = PH_IDLE;
                    st_d.cnt  = '0;
                    st_d.rx   = rx_next;
                    st_d.done = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            if (shift_ev) begin
                st_d.tsh  = {st_q.tsh[W-2:0], 1'b0};
                st_d.miso = st_q.tsh[W-2];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= PH_IDLE;
            st_q.cnt  <= '0;
            st_q.tsh  <= '0;
            st_q.rsh  <= '0;
            st_q.miso <= 1'b0;
            st_q.oe   <= 1'b0;
            st_q.rx   <= '0;
            st_q.done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign miso_o    = st_q.miso;
    assign miso_oe_o = st_q.oe;
    assign rx_data_o = st_q.rx;
    assign done_o    = st_q.done;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done); // R7
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> $past(st_q.ph == PH_SHIFT)); // R7
    AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_SHIFT && ss_n_i) |=> (!st_q.done && st_q.ph == PH_IDLE)); // R10
    AST_OE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_i |=> !miso_oe_o); // R2
    AST_SHIFT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_SHIFT && !ss_n_i && !shift_ev) |=> $stable(st_q.tsh)); // R8

endmodule

// File: rtl/spi_tgt_buffered.sv
module spi_tgt_buffered
    import spi_tgt_pkg::*;
#(
    parameter int unsigned W = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_cpol,
    input  logic         cfg_cpha,
    input  logic         sck_i,
    input  logic         mosi_i,
    input  logic         ss_n_i,
    output logic         miso_o,
    output logic         miso_oe_o,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] rx_data_o,
    output logic         done_o
);

    localparam int unsigned NPIN = 3;
    localparam logic [NPIN-1:0] PIN_RST = 3'b100;

    logic [NPIN-1:0] pins_s;
    logic            sck_s, mosi_s, ss_s;
    sck_ev_t         ev;
    logic            ss_fall;
    logic [W-1:0]    hold_d, hold_q;

    spi_tgt_sync #(
        .WIDTH  (NPIN),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({ss_n_i, mosi_i, sck_i}),
        .q_o  (pins_s)
    );

    assign sck_s  = pins_s[0];
    assign mosi_s = pins_s[1];
    assign ss_s   = pins_s[2];

    spi_tgt_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpol_i   (cfg_cpol),
        .sck_i    (sck_s),
        .ss_n_i   (ss_s),
        .ev_o     (ev),
        .ss_fall_o(ss_fall)
    );

    always_comb begin
        hold_d = wr_en_i ? wr_data_i : hold_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    spi_tgt_shifter #(.W(W)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpha_i   (cfg_cpha),
        .ev_i     (ev),
        .ss_fall_i(ss_fall),
        .ss_n_i   (ss_s),
        .mosi_i   (mosi_s),
        .load_i   (hold_q),
        .miso_o   (miso_o),
        .miso_oe_o(miso_oe_o),
        .rx_data_o(rx_data_o),
        .done_o   (done_o)
    );

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(hold_q)); // R11

endmodule

// File: tb/spi_tgt_buffered_tb.sv
module spi_tgt_buffered_tb;

    localparam int HALF = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
    logic       miso, miso_oe, done;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rx_data;

    int errors = 0;
    int checks = 0;
    int done_cnt = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    spi_tgt_buffered u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_cpol (cfg_cpol),
        .cfg_cpha (cfg_cpha),
        .sck_i    (sck),
        .mosi_i   (mosi),
        .ss_n_i   (ss_n),
        .miso_o   (miso),
        .miso_oe_o(miso_oe),
        .wr_en_i  (wr_en),
        .wr_data_i(wr_data),
        .rx_data_o(rx_data),
        .done_o   (done)
    );

    always @(negedge clk) if (rst_n && done) done_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sel(input logic lvl);
        ss_n = lvl;
        cyc(HALF);
    endtask

    // master side: drives nbits of mval, records MISO at the capture edge
    task automatic xfer(input logic [7:0] mval, input int nbits, output logic [7:0] got);
        got = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            if (!cfg_cpha) begin
                mosi = mval[i];
                cyc(HALF);
                sck = ~cfg_cpol;
                got[i] = miso;
                cyc(HALF);
                sck = cfg_cpol;
            end else begin
                sck = ~cfg_cpol;
                mosi = mval[i];
                cyc(HALF);
                sck = cfg_cpol;
                got[i] = miso;
                cyc(HALF);
            end
        end
        cyc(8);
    endtask

    function automatic logic [7:0] pat(input int m, input int k);
        if (k == 0) return 8'h00;
        if (k == 1) return 8'hFF;
        return 8'((k * 53 + m * 29 + 8'h5A) & 8'hFF);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] got, got2, tv, mv, rx_prev;
        int d0;
        cyc(5);
        rst_n = 1'b1;
        cyc(4);
        chk("R1 oe", int'(miso_oe), 0);
        chk("R1 done", done_cnt, 0);
        chk("R1 rx", int'(rx_data), 0);

        // sweep all modes
        for (int m = 0; m < 4; m++) begin
            cfg_cpol = m[1];
            cfg_cpha = m[0];
            sck = cfg_cpol;
            cyc(10);
            for (int k = 0; k < 8; k++) begin
                tv = pat(m, k);
                mv = ~tv ^ 8'(k * 17);
                host_write(tv);
                d0 = done_cnt;
                sel(1'b0);
                chk("R2 oe on", int'(miso_oe), 1);
                xfer(mv, 8, got);
                chk(cfg_cpha ? "R4 miso byte" : "R3 miso byte", int'(got), int'(tv));
                chk(cfg_cpol ? "R6 rx byte" : "R5 rx byte", int'(rx_data), int'(mv));
                chk("R7 one pulse", done_cnt - d0, 1);
                sel(1'b1);
                chk("R2 oe off", int'(miso_oe), 0);
            end
        end

        // lockout: write during a phase-0 byte
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; sck = 1'b0; cyc(10);
        host_write(8'h3C);
        sel(1'b0);
        fork
            xfer(8'h81, 8, got);
            begin cyc(40); host_write(8'hC3); end
        join
        chk("R8 current byte", int'(got), 8'h3C);
        sel(1'b1);
        sel(1'b0);
        xfer(8'h42, 8, got);
        chk("R8 next byte", int'(got), 8'hC3);
        sel(1'b1);
        sel(1'b0);
        xfer(8'h24, 8, got);
        chk("R11 resend", int'(got), 8'hC3);
        sel(1'b1);

        // phase 1, select held low over two bytes
        cfg_cpha = 1'b1; cyc(10);
        host_write(8'h96);
        d0 = done_cnt;
        sel(1'b0);
        fork
            xfer(8'h11, 8, got);
            begin cyc(50); host_write(8'h69); end
        join
        chk("R9 first byte", int'(got), 8'h96);
        xfer(8'h22, 8, got2);
        chk("R9 second byte", int'(got2), 8'h69);
        chk("R9 second rx", int'(rx_data), 8'h22);
        chk("R9 two pulses", done_cnt - d0, 2);
        sel(1'b1);

        // abort in both phases
        for (int p = 0; p < 2; p++) begin
            cfg_cpha = p[0]; cyc(10);
            host_write(8'hE7);
            rx_prev = rx_data;
            d0 = done_cnt;
            sel(1'b0);
            xfer(8'h5B, 3, got);
            sel(1'b1);
            chk("R10 no pulse", done_cnt - d0, 0);
            chk("R10 rx kept", int'(rx_data), int'(rx_prev));
            chk("R10 oe off", int'(miso_oe), 0);
            sel(1'b0);
            xfer(8'hA4, 8, got);
            chk("R10 restart byte", int'(got), 8'hE7);
            chk("R10 restart rx", int'(rx_data), 8'hA4);
            chk("R10 one pulse", done_cnt - d0, 1);
            sel(1'b1);
        end

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule